// File: doc/BRIEF.md
# Buffered Half-Duplex SPI Flash Master

This block is a register-driven SPI master for flash-style transactions. Software fills an opcode word and a 32-byte data buffer. It programs three separate bit counts: a command phase, a write-data phase and a read phase. It then sets a start bit. The engine divides the system clock to make SCK and shifts out the command bits, then the write data, then the read bits. The read bits are captured back into the same data buffer. Software polls the busy flag to learn when the transaction has finished.

The block drives one chip-select line for each attached device. Each line follows a bit that software owns, so a device can stay selected across several back-to-back transactions. The block runs in SPI mode 0 only and does not transmit and receive at the same time.

Register word addresses: 0 transaction, 1 opcode, 2 to 9 data words 0 to 7, 10 bit counts, 11 master control, 12 chip select.

Top module: `spi_flash_master`

## Requirements
- R1: Writing a 1 to bit 8 of the transaction register (address 0) starts a transaction. Bit 16 of that register reads 1 while the transaction runs and 0 afterwards. Busy lasts exactly (total bits) x (divisor) clock cycles.
- R2: A start request written while busy is set is ignored. The running transaction keeps its length and its bit count.
- R3: The bit-count register (address 10) holds the command bit count in bits 29:24, the read bit count in bits 20:12 and the write-data bit count in bits 8:0. A command count above 32 acts as 32, and a data or read count above 256 acts as 256. The register reads back as written.
- R4: The phases run in a fixed order: command, then write data, then read. A phase with a zero count is skipped. If all three counts are zero, a start does nothing.
- R5: The command phase sends opcode (address 1) bits [n-1:0] for an n-bit count, highest bit first. Fewer than 32 bits are therefore right-aligned in the word.
- R6: Write-data byte k is taken from data word k/4, bits 8*(k%4)+7 : 8*(k%4). Each byte goes out MSB first, or LSB first when bit 3 of master control (address 11) is set.
- R7: Read bit i is stored in byte i/8 of the buffer, which uses the same little-endian word packing as R6. Inside the byte it lands at bit 7-(i%8), or at bit i%8 when the LSB-first bit is set. Bytes that no read bit reaches are left unchanged.
- R8: Master control bits 27:16 hold the divisor minus 2, so the divisor runs from 2 to 4097. Each SCK period lasts the divisor in clock cycles, with SCK high for floor(divisor/2) of those cycles. The field reads back as written.
- R9: Mode 0 timing applies. SCK is low whenever the block is idle. MOSI changes only while SCK is low. MISO is sampled while SCK is high.
- R10: The chip-select register (address 12) has one bit per device. Output csN[d] is low exactly when bit d is set, and it holds that level across and between transactions.
- R11: Reset clears busy, releases all chip selects, and zeroes the opcode, counts, divisor field, LSB-first bit and data buffer. SCK and MOSI are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register word address |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| csN | output | NUM_CS | Active-low chip selects |

## Verification
The assertions take for granted that software leaves the counts, the divisor, the buffer and the chip-select register alone while busy is set. The bit-index and chip-select checks only hold under that rule. The stimulus keeps to it: every configuration write happens before the start bit, and the bench then polls busy until it clears. The only bus write issued during a transaction is the deliberate repeated start request. A device model answers on MISO, changing its bit on the falling SCK edge, so the read path sees data that stays steady across each rising edge.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int LEN_W = 9;   // data/read bit-count field width
  localparam int CMD_W = 6;   // command bit-count field width

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_TX  = 2'd1,
    PH_RX  = 2'd2
  } phase_t;

  typedef struct packed {
    logic             active;
    phase_t           phase;
    logic [LEN_W-1:0] bitIdx;
    logic             sampleStb;
  } ctl_t;
endpackage

// File: rtl/spim_control.sv
module spim_control
  import spim_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CMD_W-1:0] cmdLen,
  input  logic [LEN_W-1:0] txLen,
  input  logic [LEN_W-1:0] rxLen,
  input  logic [DIV_W-1:0] divField,
  output logic             busy,
  output logic             sck,
  output ctl_t             ctl
);
  localparam int CNT_W = DIV_W + 1;

  logic             active;
  phase_t           phase;
  logic [LEN_W-1:0] bitIdx;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] divisor;
  logic [CNT_W-1:0] lowLen;
  logic [LEN_W-1:0] curLen;
  logic             anyWork;
  phase_t           firstPhase;
  phase_t           nextPhase;
  logic             hasNext;
  logic             bitEnd;
  logic             phaseEnd;

  assign divisor = CNT_W'(divField) + CNT_W'(2);
  assign lowLen  = CNT_W'((divisor + CNT_W'(1)) >> 1);
  assign bitEnd  = (cnt == divisor - CNT_W'(1));

  always_comb begin
    unique case (phase)
      PH_CMD:  curLen = LEN_W'(cmdLen);
      PH_TX:   curLen = txLen;
      default: curLen = rxLen;
    endcase
  end

  assign phaseEnd = (bitIdx == curLen - LEN_W'(1));

  always_comb begin
    anyWork = (cmdLen != '0) || (txLen != '0) || (rxLen != '0);
    if (cmdLen != '0)     firstPhase = PH_CMD;
    else if (txLen != '0) firstPhase = PH_TX;
    else                  firstPhase = PH_RX;
  end

  always_comb begin
    hasNext   = 1'b0;
    nextPhase = PH_RX;
    if (phase == PH_CMD) begin
      if (txLen != '0) begin
        hasNext   = 1'b1;
        nextPhase = PH_TX;
      end else if (rxLen != '0) begin
        hasNext   = 1'b1;
        nextPhase = PH_RX;
      end
    end else if (phase == PH_TX) begin
      hasNext   = (rxLen != '0);
      nextPhase = PH_RX;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= PH_CMD;
      bitIdx <= '0;
      cnt    <= '0;
    end else if (!active) begin
      if (startReq && anyWork) begin
        active <= 1'b1;
        phase  <= firstPhase;
        bitIdx <= '0;
        cnt    <= '0;
      end
    end else if (bitEnd) begin
      cnt <= '0;
      if (phaseEnd) begin
        bitIdx <= '0;
        if (hasNext) phase  <= nextPhase;
        else         active <= 1'b0;
      end else begin
        bitIdx <= bitIdx + LEN_W'(1);
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign busy          = active;
  assign sck           = active && (cnt >= lowLen);
  assign ctl.active    = active;
  assign ctl.phase     = phase;
  assign ctl.bitIdx    = bitIdx;
  assign ctl.sampleStb = active && (cnt == lowLen);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (cnt < divisor)); // R8
  AST_BIT_IN_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitIdx < curLen)); // R4
  AST_PHASE_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> (phase >= $past(phase))); // R4
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int NUM_CS     = 2,
  parameter int DIV_W      = 12,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busy,
  input  ctl_t              ctl,
  input  logic              misoIn,
  output logic              startReq,
  output logic [CMD_W-1:0]  cmdLen,
  output logic [LEN_W-1:0]  txLen,
  output logic [LEN_W-1:0]  rxLen,
  output logic [DIV_W-1:0]  divField,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN
);
  localparam int DATA_WORDS  = DATA_BYTES / 4;
  localparam int BYTE_IDX_W  = $clog2(DATA_BYTES);
  localparam int MAX_CMD     = 32;
  localparam int MAX_DATA    = DATA_BYTES * 8;
  localparam int A_XFER      = 0;
  localparam int A_OPCODE    = 1;
  localparam int A_DATA      = 2;
  localparam int A_COUNT     = A_DATA + DATA_WORDS;
  localparam int A_MASTER    = A_COUNT + 1;
  localparam int A_CS        = A_COUNT + 2;

  logic [31:0]       opcode;
  logic [CMD_W-1:0]  cmdField;
  logic [LEN_W-1:0]  txField;
  logic [LEN_W-1:0]  rxField;
  logic              lsbFirst;
  logic [NUM_CS-1:0] csReg;
  logic [7:0]        dataBuf [DATA_BYTES];

  logic                  rxStb;
  logic [BYTE_IDX_W-1:0] bufByte;
  logic [2:0]            bitInByte;
  logic [2:0]            bitPos;
  logic [4:0]            opBitSel;

  assign startReq = regWr && (regAddr == ADDR_W'(A_XFER)) && regWrData[8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode   <= '0;
      cmdField <= '0;
      txField  <= '0;
      rxField  <= '0;
      divField <= '0;
      lsbFirst <= 1'b0;
      csReg    <= '0;
    end else if (regWr) begin
      if (regAddr == ADDR_W'(A_OPCODE)) opcode <= regWrData;
      if (regAddr == ADDR_W'(A_COUNT)) begin
        cmdField <= regWrData[29:24];
        rxField  <= regWrData[20:12];
        txField  <= regWrData[8:0];
      end
      if (regAddr == ADDR_W'(A_MASTER)) begin
        divField <= regWrData[16 +: DIV_W];
        lsbFirst <= regWrData[3];
      end
      if (regAddr == ADDR_W'(A_CS)) csReg <= regWrData[NUM_CS-1:0];
    end
  end

  // effective lengths, clamped to what the buffers hold
  assign cmdLen = (cmdField > CMD_W'(MAX_CMD)) ? CMD_W'(MAX_CMD) : cmdField;
  assign txLen  = (txField > LEN_W'(MAX_DATA)) ? LEN_W'(MAX_DATA) : txField;
  assign rxLen  = (rxField > LEN_W'(MAX_DATA)) ? LEN_W'(MAX_DATA) : rxField;

  assign bufByte   = ctl.bitIdx[3 +: BYTE_IDX_W];
  assign bitInByte = ctl.bitIdx[2:0];
  assign bitPos    = lsbFirst ? bitInByte : ~bitInByte;
  assign rxStb     = ctl.sampleStb && (ctl.phase == PH_RX);
  assign opBitSel  = 5'(cmdLen - CMD_W'(1) - ctl.bitIdx[CMD_W-1:0]);

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataBuf[b] <= '0;
      end else if (regWr && (regAddr == ADDR_W'(A_DATA + b / 4))) begin
        dataBuf[b] <= regWrData[8 * (b % 4) +: 8];
      end else if (rxStb && (bufByte == BYTE_IDX_W'(b))) begin
        dataBuf[b][bitPos] <= misoIn;
      end
    end
  end

  always_comb begin
    mosi = 1'b0;
    if (ctl.active) begin
      unique case (ctl.phase)
        PH_CMD:  mosi = opcode[opBitSel];
        PH_TX:   mosi = dataBuf[bufByte][bitPos];
        default: mosi = 1'b0;
      endcase
    end
  end

  assign csN = ~csReg;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(A_XFER))   regRdData[16] = busy;
    if (regAddr == ADDR_W'(A_OPCODE)) regRdData = opcode;
    if (regAddr == ADDR_W'(A_COUNT))
      regRdData = {2'b00, cmdField, 3'b000, rxField, 3'b000, txField};
    if (regAddr == ADDR_W'(A_MASTER)) begin
      regRdData[16 +: DIV_W] = divField;
      regRdData[3]           = lsbFirst;
    end
    if (regAddr == ADDR_W'(A_CS)) regRdData[NUM_CS-1:0] = csReg;
    for (int w = 0; w < DATA_WORDS; w++) begin
      if (regAddr == ADDR_W'(A_DATA + w))
        regRdData = {dataBuf[4*w+3], dataBuf[4*w+2], dataBuf[4*w+1], dataBuf[4*w]};
    end
  end

  AST_RX_IN_BUFFER: assert property (@(posedge clk) disable iff (!rstN)
    rxStb |-> (ctl.bitIdx < LEN_W'(MAX_DATA))); // R7
  AST_CMD_BIT_IN_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.phase == PH_CMD) |-> (ctl.bitIdx < LEN_W'(cmdLen))); // R5
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
  import spim_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int NUM_CS     = 2,
  parameter int DIV_W      = 12,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);
  ctl_t             ctl;
  logic             busy;
  logic             startReq;
  logic [CMD_W-1:0] cmdLen;
  logic [LEN_W-1:0] txLen;
  logic [LEN_W-1:0] rxLen;
  logic [DIV_W-1:0] divField;

  spim_datapath #(
    .DATA_BYTES(DATA_BYTES), .NUM_CS(NUM_CS), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .ctl(ctl),
    .misoIn(miso), .startReq(startReq), .cmdLen(cmdLen), .txLen(txLen),
    .rxLen(rxLen), .divField(divField), .mosi(mosi), .csN(csN)
  );

  spim_control #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdLen(cmdLen),
    .txLen(txLen), .rxLen(rxLen), .divField(divField), .busy(busy),
    .sck(sck), .ctl(ctl)
  );

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi)); // R9
  AST_CS_STEADY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csN)); // R10
endmodule

// File: tb/test_spi_flash_master.sv
module test_spi_flash_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [1:0]  csN;

  always #4 clk = ~clk;

  spi_flash_master i_spi_flash_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .sck(sck), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  int total = 0;
  int bad = 0;
  int rises = 0;
  int txTotal = 0;
  int curSeed = 0;
  logic wireBit [512];
  logic [1:0] csAtRise [512];

  typedef struct packed {
    logic [5:0]  cmd;
    logic [31:0] op;
    logic [8:0]  tx;
    logic [8:0]  rx;
    logic [11:0] divF;
    logic        lsb;
    logic [1:0]  cs;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{6'd8,  32'h0000_0003, 9'd24,  9'd32,  12'd0, 1'b0, 2'd1},
    '{6'd32, 32'hA1B2_C3D4, 9'd0,   9'd64,  12'd1, 1'b0, 2'd2},
    '{6'd0,  32'h0000_0000, 9'd40,  9'd0,   12'd2, 1'b1, 2'd1},
    '{6'd16, 32'h0000_9F5A, 9'd256, 9'd0,   12'd0, 1'b0, 2'd1},
    '{6'd8,  32'h0000_000B, 9'd0,   9'd256, 12'd0, 1'b1, 2'd2},
    '{6'd24, 32'h0012_3456, 9'd8,   9'd16,  12'd5, 1'b0, 2'd3}
  };

  function automatic logic [7:0] txByte(int k, int s);
    return 8'((k * 37 + s * 11 + 5) & 255);
  endfunction

  function automatic logic rxPat(int i, int s);
    return ((i * 29 + s * 3) % 7) > 2;
  endfunction

  always @(posedge sck) begin
    if (rises < 512) begin
      wireBit[rises]  = mosi;
      csAtRise[rises] = csN;
    end
    rises = rises + 1;
  end

  always @(negedge sck) begin
    if (rises >= txTotal) miso = rxPat(rises - txTotal, curSeed);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = 4'(addr);
    regWrData = data;
    regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input int addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = 4'(addr);
    #1 data = regRdData;
  endtask

  // count busy cycles after a start; optionally re-issue start at cycle reStartAt
  task automatic runAndCount(input int reStartAt, output int busyCyc, output int hiCyc);
    busyCyc = 0;
    hiCyc = 0;
    regWrite(0, 32'h100);
    regAddr = 4'd0;
    #1;
    for (int n = 0; n < 20000 && regRdData[16]; n++) begin
      busyCyc++;
      if (sck) hiCyc++;
      if (n == reStartAt) begin
        regWrData = 32'h100;
        regWr = 1'b1;
      end
      @(negedge clk);
      regWr = 1'b0;
      #1;
    end
  endtask

  task automatic runXfer(input vec_t v, input int seed, input string tag);
    int effCmd, bits, dv, busyCyc, hiCyc, errs, csErr;
    logic [31:0] w;
    logic [7:0] expB;
    effCmd = (v.cmd > 32) ? 32 : int'(v.cmd);
    bits = effCmd + int'(v.tx) + int'(v.rx);
    dv = int'(v.divF) + 2;
    curSeed = seed;
    txTotal = effCmd + int'(v.tx);
    regWrite(12, {30'd0, v.cs});
    regWrite(11, {4'd0, v.divF, 12'd0, v.lsb, 3'd0});
    regWrite(1, v.op);
    for (int k = 0; k < 8; k++)
      regWrite(2 + k, {txByte(4*k+3, seed), txByte(4*k+2, seed),
                       txByte(4*k+1, seed), txByte(4*k, seed)});
    regWrite(10, {2'd0, v.cmd, 3'd0, v.rx, 3'd0, v.tx});
    rises = 0;
    miso = rxPat(0, seed);
    runAndCount(-1, busyCyc, hiCyc);
    check(busyCyc == bits * dv, {tag, " R1 busy length"}, busyCyc, bits * dv);
    check(hiCyc == bits * (dv / 2), {tag, " R8 sck high cycles"}, hiCyc, bits * (dv / 2));
    check(rises == bits, {tag, " R4 sck edge count"}, rises, bits);
    errs = 0;
    csErr = 0;
    for (int i = 0; i < bits && i < 512; i++) begin
      logic e;
      if (i < effCmd) e = v.op[effCmd - 1 - i];
      else if (i < txTotal) begin
        int j = i - effCmd;
        e = txByte(j / 8, seed)[v.lsb ? (j % 8) : (7 - j % 8)];
      end else e = 1'b0;
      if (i < txTotal && wireBit[i] !== e) errs++;
      if (csAtRise[i] !== ~v.cs) csErr++;
    end
    check(errs == 0, {tag, " R5 R6 mosi bit errors"}, errs, 0);
    check(csErr == 0, {tag, " R10 cs held during transfer"}, csErr, 0);
    errs = 0;
    for (int k = 0; k < 8; k++) begin
      regRead(2 + k, w);
      for (int b = 0; b < 4; b++) begin
        int by = 4 * k + b;
        if (by < int'(v.rx) / 8) begin
          for (int p = 0; p < 8; p++)
            expB[v.lsb ? p : 7 - p] = rxPat(by * 8 + p, seed);
        end else expB = txByte(by, seed);
        if (w[8*b +: 8] !== expB) errs++;
      end
    end
    check(errs == 0, {tag, " R7 read buffer byte errors"}, errs, 0);
    check(csN == ~v.cs, {tag, " R10 cs held after transfer"}, int'(csN), int'(~v.cs));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    int busyCyc, hiCyc;
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R11: reset state
    regRead(0, r);  check(r == 0, "R11 transaction reg", int'(r), 0);
    regRead(10, r); check(r == 0, "R11 count reg", int'(r), 0);
    regRead(11, r); check(r == 0, "R11 master reg", int'(r), 0);
    regRead(2, r);  check(r == 0, "R11 data word 0", int'(r), 0);
    regRead(12, r); check(r == 0, "R11 cs reg", int'(r), 0);
    check(csN == 2'b11 && sck == 1'b0 && mosi == 1'b0, "R11 pins idle",
          int'({csN, sck, mosi}), 12);

    // table-driven transactions
    for (int n = 0; n < NV; n++) runXfer(VECS[n], n + 1, $sformatf("vec%0d", n));

    // R3 R8: register readback
    regRead(10, r);
    check(r == {2'd0, 6'd24, 3'd0, 9'd16, 3'd0, 9'd8}, "R3 count readback",
          int'(r), int'({2'd0, 6'd24, 3'd0, 9'd16, 3'd0, 9'd8}));
    regRead(11, r);
    check(r == 32'h0005_0000, "R8 master readback", int'(r), 32'h0005_0000);

    // R3: command count above 32 acts as 32
    v = '{6'd40, 32'hC3A5_0F96, 9'd0, 9'd0, 12'd0, 1'b0, 2'd1};
    runXfer(v, 9, "clampR3");

    // R4: all counts zero, start does nothing
    regWrite(10, 32'd0);
    rises = 0;
    runAndCount(-1, busyCyc, hiCyc);
    check(busyCyc == 0 && rises == 0, "R4 empty transaction", busyCyc + rises, 0);

    // R2: start while busy ignored
    regWrite(11, {4'd0, 12'd10, 16'd0});
    regWrite(10, {2'd0, 6'd8, 24'd0});
    txTotal = 8;
    rises = 0;
    runAndCount(20, busyCyc, hiCyc);
    check(busyCyc == 96, "R2 busy length with repeated start", busyCyc, 96);
    check(rises == 8, "R2 bit count with repeated start", rises, 8);
    repeat (20) @(negedge clk);
    #1 check(rises == 8 && sck == 1'b0, "R2 no second transaction", rises, 8);

    // R8: largest divisor
    regWrite(11, {4'd0, 12'hFFF, 16'd0});
    regWrite(10, {2'd0, 6'd2, 24'd0});
    rises = 0;
    runAndCount(-1, busyCyc, hiCyc);
    check(busyCyc == 2 * 4097, "R8 max divisor length", busyCyc, 2 * 4097);
    check(hiCyc == 2 * 2048, "R8 max divisor high time", hiCyc, 2 * 2048);

    // R10: releasing chip selects
    regWrite(12, 32'd0);
    #1 check(csN == 2'b11, "R10 cs released", int'(csN), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule